// File: doc/BRIEF.md
# USB Start-of-Frame Number Capture

This block sits behind a USB receiver that already delivers packet bytes with line decoding, bit unstuffing and PID validation done. It watches that byte stream for Start of Frame tokens. The moment the SOF PID byte is accepted, it raises a sticky SOF interrupt flag, so firmware can start per-frame work before the rest of the token has arrived. It then takes the two payload bytes, pulls out the 11-bit frame number and the 5-bit CRC, and checks the CRC. It stores the frame number together with a pair of status flags, one for a good CRC and one for a bad one.

Software sees two read-only byte registers. One holds the low eight frame bits. The other holds the top three frame bits and the two CRC flags. A corrupted CRC does not stop the frame number from being stored. A packet cut short keeps the old number and reports an error. The frame number and both flags change in the same clock cycle, so a read never mixes values from two tokens.

Top module: `usb_sof_capture`

## Requirements
- R1: When the second payload byte of an SOF packet is accepted, the frame number is stored and becomes visible one clock edge later. Payload bytes arrive least significant bit first: frame bits 7:0 are the first byte, and frame bits 10:8 are bits 2:0 of the second byte. `frame_lo` shows frame bits 7:0, and `frame_hi[2:0]` shows frame bits 10:8.
- R2: After reset, `frame_lo`, `frame_hi` and `sof_irq` are all zero.
- R3: Bits 7, 6 and 3 of `frame_hi` always read 0.
- R4: The CRC field sits in bits 7:3 of the second payload byte. It is the bit-inverted remainder of the polynomial x^5+x^2+1, preset to all ones, taken over the 11 frame bits, with the remainder's top bit placed in byte bit 3. Run all 16 payload bits through the checker: a residual of 5'b01100 sets `frame_hi[5]` (CRC good) and clears `frame_hi[4]`.
- R5: Any other residual sets `frame_hi[4]` (CRC error) and clears `frame_hi[5]`. After any SOF, exactly one of the two flags is set.
- R6: An SOF whose CRC fails still replaces the stored frame number with the received bits.
- R7: `sof_irq` is set one edge after an accepted byte carries start-of-packet with value 0xA5. This happens before any payload byte is taken and before the frame registers change.
- R8: An SOF packet can end, by `rx_eop` or by a new start of packet, after fewer than two payload bytes. In that case the frame number stays the same, `frame_hi[4]` is set and `frame_hi[5]` is cleared.
- R9: `sof_irq` stays set until `irq_clr` is high at a clock edge. If `irq_clr` is high in the same cycle as an SOF PID, the flag ends up set.
- R10: Packets with any other PID, and bytes received outside a packet, leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is present on `rx_data` |
| rx_sop | input | 1 | With `rx_valid`: this byte is the PID of a new packet |
| rx_eop | input | 1 | Packet ended (no byte in this cycle) |
| rx_data | input | 8 | Received byte |
| irq_clr | input | 1 | Write-one-to-clear strobe for the SOF flag |
| frame_lo | output | 8 | Frame number bits 7:0 |
| frame_hi | output | 8 | {2'b0, crc_ok, crc_err, 1'b0, frame[10:8]} |
| sof_irq | output | 1 | Sticky SOF interrupt flag |

## Verification
Every result is one edge away from the stimulus that causes it. The interrupt flag follows the edge that takes the PID or the clear strobe. Both byte registers follow the edge that takes the second payload byte or the early end of packet. The bench drives each input on the falling edge and compares outputs 1 ns after the next rising edge. It checks the interrupt flag after every cycle, and it checks the byte registers right after the cycle that should commit them. It also checks the registers after the PID cycle, to confirm they have not moved yet.

// File: rtl/usb_sofcap_pkg.sv
package usb_sofcap_pkg;

    localparam int          BYTE_W       = 8;
    localparam int          FRAME_W      = 11;
    localparam int          CRC_W        = 5;
    localparam int          PAYLOAD_BITS = 2 * BYTE_W;
    localparam int          FRAME_HI_W   = FRAME_W - BYTE_W;

    localparam logic [BYTE_W-1:0] SOF_PID      = 8'hA5;
    localparam logic [CRC_W-1:0]  CRC_POLY     = 5'b00101;
    localparam logic [CRC_W-1:0]  CRC_PRESET   = 5'b11111;
    localparam logic [CRC_W-1:0]  CRC_RESIDUAL = 5'b01100;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_LO   = 2'd1,
        PS_HI   = 2'd2
    } parse_st_e;

    typedef struct packed {
        parse_st_e         st;
        logic [BYTE_W-1:0] lo_byte;
    } parse_s;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic               ok;
        logic               err;
        logic               irq;
    } regs_s;

    function automatic logic [CRC_W-1:0] crc5_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & CRC_POLY);
    endfunction

endpackage

// File: rtl/usb_sofcap_crc5.sv
module usb_sofcap_crc5
    import usb_sofcap_pkg::*;
#(
    parameter int NBITS = PAYLOAD_BITS
) (
    input  logic [NBITS-1:0] bits_in,
    output logic [CRC_W-1:0] residual,
    output logic             good
);

    logic [CRC_W-1:0] chain [0:NBITS];

    assign chain[0] = CRC_PRESET;

    genvar i;
    generate
        for (i = 0; i < NBITS; i++) begin : g_stage
            assign chain[i+1] = crc5_step(chain[i], bits_in[i]);
        end
    endgenerate

    assign residual = chain[NBITS];
    assign good     = (chain[NBITS] == CRC_RESIDUAL);

endmodule

// File: rtl/usb_sofcap_parser.sv
module usb_sofcap_parser
    import usb_sofcap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_valid,
    input  logic               rx_sop,
    input  logic               rx_eop,
    input  logic [BYTE_W-1:0]  rx_data,
    output logic               pid_hit,
    output logic               commit_full,
    output logic               commit_short,
    output logic [FRAME_W-1:0] frame_new,
    output logic               crc_good
);

    parse_s cur_q, nxt_d;

    assign pid_hit   = rx_valid && rx_sop && (rx_data == SOF_PID);
    assign frame_new = {rx_data[FRAME_HI_W-1:0], cur_q.lo_byte};

    usb_sofcap_crc5 #(.NBITS(PAYLOAD_BITS)) u_crc (
        .bits_in  ({rx_data, cur_q.lo_byte}),
        .residual (),
        .good     (crc_good)
    );

    always_comb begin
        nxt_d        = cur_q;
        commit_full  = 1'b0;
        commit_short = 1'b0;
        if (rx_valid && rx_sop) begin
            if (cur_q.st != PS_IDLE) commit_short = 1'b1;
            nxt_d.st = pid_hit ? PS_LO : PS_IDLE;
        end else if (rx_eop) begin
            if (cur_q.st != PS_IDLE) commit_short = 1'b1;
            nxt_d.st = PS_IDLE;
        end else if (rx_valid) begin
            case (cur_q.st)
                PS_LO: begin
                    nxt_d.lo_byte = rx_data;
                    nxt_d.st      = PS_HI;
                end
                PS_HI: begin
                    commit_full = 1'b1;
                    nxt_d.st    = PS_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: PS_IDLE, lo_byte: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    AST_PID_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        pid_hit |=> (cur_q.st == PS_LO)); // R7

    AST_FULL_NEEDS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        commit_full |-> $past(cur_q.st) == PS_LO); // R1

endmodule

// File: rtl/usb_sofcap_regs.sv
module usb_sofcap_regs
    import usb_sofcap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pid_hit,
    input  logic               commit_full,
    input  logic               commit_short,
    input  logic [FRAME_W-1:0] frame_new,
    input  logic               crc_good,
    input  logic               irq_clr,
    output logic [BYTE_W-1:0]  frame_lo,
    output logic [BYTE_W-1:0]  frame_hi,
    output logic               sof_irq
);

    regs_s cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (commit_full) begin
            nxt_d.frame = frame_new;
            nxt_d.ok    = crc_good;
            nxt_d.err   = !crc_good;
        end else if (commit_short) begin
            nxt_d.ok    = 1'b0;
            nxt_d.err   = 1'b1;
        end
        if (pid_hit) begin
            nxt_d.irq = 1'b1;
        end else if (irq_clr) begin
            nxt_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign frame_lo = cur_q.frame[BYTE_W-1:0];
    assign frame_hi = {2'b00, cur_q.ok, cur_q.err, 1'b0, cur_q.frame[FRAME_W-1:BYTE_W]};
    assign sof_irq  = cur_q.irq;

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cur_q.ok && cur_q.err)); // R5

    AST_COMMIT_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_full || commit_short) |=> (cur_q.ok ^ cur_q.err)); // R5

    AST_SHORT_KEEPS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_short && !commit_full) |=> $stable(cur_q.frame)); // R8

    AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        pid_hit |=> sof_irq); // R9

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_irq && !irq_clr) |=> sof_irq); // R9

    AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !pid_hit) |=> !sof_irq); // R9

endmodule

// File: rtl/usb_sof_capture.sv
module usb_sof_capture
    import usb_sofcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_sop,
    input  logic              rx_eop,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              irq_clr,
    output logic [BYTE_W-1:0] frame_lo,
    output logic [BYTE_W-1:0] frame_hi,
    output logic              sof_irq
);

    logic               pid_hit;
    logic               commit_full;
    logic               commit_short;
    logic [FRAME_W-1:0] frame_new;
    logic               crc_good;

    usb_sofcap_parser u_parser (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_sop       (rx_sop),
        .rx_eop       (rx_eop),
        .rx_data      (rx_data),
        .pid_hit      (pid_hit),
        .commit_full  (commit_full),
        .commit_short (commit_short),
        .frame_new    (frame_new),
        .crc_good     (crc_good)
    );

    usb_sofcap_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .pid_hit      (pid_hit),
        .commit_full  (commit_full),
        .commit_short (commit_short),
        .frame_new    (frame_new),
        .crc_good     (crc_good),
        .irq_clr      (irq_clr),
        .frame_lo     (frame_lo),
        .frame_hi     (frame_hi),
        .sof_irq      (sof_irq)
    );

    AST_PID_BEFORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        pid_hit |=> $stable(frame_lo)); // R7

endmodule

// File: tb/usb_sof_capture_bench.sv
module usb_sof_capture_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic       rx_sop = 1'b0;
    logic       rx_eop = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       irq_clr = 1'b0;
    logic [7:0] frame_lo;
    logic [7:0] frame_hi;
    logic       sof_irq;

    int vectors = 0;
    int fails = 0;

    logic [10:0] exp_frame = '0;
    logic        exp_ok = 1'b0;
    logic        exp_err = 1'b0;
    logic        exp_irq = 1'b0;

    always #4 clk = ~clk;

    usb_sof_capture u_usb_sof_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_sop   (rx_sop),
        .rx_eop   (rx_eop),
        .rx_data  (rx_data),
        .irq_clr  (irq_clr),
        .frame_lo (frame_lo),
        .frame_hi (frame_hi),
        .sof_irq  (sof_irq)
    );

    function automatic logic [4:0] crc_field(input logic [10:0] f);
        logic [4:0] r;
        logic       fb;
        logic [4:0] inv;
        logic [4:0] fld;
        r = 5'b11111;
        for (int i = 0; i < 11; i++) begin
            fb = f[i] ^ r[4];
            r  = {r[3:0], 1'b0} ^ (fb ? 5'b00101 : 5'b00000);
        end
        inv = ~r;
        for (int k = 0; k < 5; k++) fld[k] = inv[4-k];
        return fld;
    endfunction

    function automatic logic [7:0] exp_hi_val();
        return {2'b00, exp_ok, exp_err, 1'b0, exp_frame[10:8]};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        check({tag, " frame_lo"}, {24'b0, frame_lo}, {24'b0, exp_frame[7:0]});
        check({tag, " frame_hi"}, {24'b0, frame_hi}, {24'b0, exp_hi_val()});
        check("R3 reserved bits", {24'b0, frame_hi & 8'hC8}, 32'h0);
    endtask

    task automatic cyc(input logic v, input logic s, input logic e,
                       input logic [7:0] d, input logic clr);
        @(negedge clk);
        rx_valid = v; rx_sop = s; rx_eop = e; rx_data = d; irq_clr = clr;
        @(posedge clk);
        #1;
        if (v && s && d == 8'hA5) exp_irq = 1'b1;
        else if (clr)             exp_irq = 1'b0;
        check("R9 sof_irq", {31'b0, sof_irq}, {31'b0, exp_irq});
    endtask

    task automatic idle(input int n, input logic clr);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 8'h00, clr);
    endtask

    // flip >= 16 means no corruption
    task automatic send_sof(input logic [10:0] f, input int flip, input logic rclr);
        logic [15:0] pay;
        pay = {crc_field(f), f};
        if (flip < 16) pay[flip] = ~pay[flip];
        cyc(1'b1, 1'b1, 1'b0, 8'hA5, rclr);
        check("R7 irq before payload", {31'b0, sof_irq}, 32'd1);
        check_regs("R7 regs unchanged after PID");
        cyc(1'b1, 1'b0, 1'b0, pay[7:0], 1'b0);
        cyc(1'b1, 1'b0, 1'b0, pay[15:8], $urandom_range(0, 1) == 1);
        exp_frame = {pay[10:8], pay[7:0]};
        exp_ok    = (flip >= 16);
        exp_err   = (flip < 16);
        if (flip >= 16) check_regs("R1 R4 good SOF");
        else            check_regs("R5 R6 corrupted SOF");
        cyc(1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
        check_regs("R10 eop after full SOF");
    endtask

    task automatic send_short(input int nbytes, input logic by_sop);
        cyc(1'b1, 1'b1, 1'b0, 8'hA5, 1'b0);
        for (int i = 0; i < nbytes; i++) cyc(1'b1, 1'b0, 1'b0, 8'($urandom), 1'b0);
        exp_ok  = 1'b0;
        exp_err = 1'b1;
        if (by_sop) begin
            cyc(1'b1, 1'b1, 1'b0, 8'hC3, 1'b0);
            check_regs("R8 truncated by new packet");
            cyc(1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
        end else begin
            cyc(1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
            check_regs("R8 truncated by eop");
        end
    endtask

    task automatic send_other(input logic [7:0] pid);
        cyc(1'b1, 1'b1, 1'b0, pid, 1'b0);
        cyc(1'b1, 1'b0, 1'b0, 8'($urandom), 1'b0);
        cyc(1'b1, 1'b0, 1'b0, 8'($urandom), 1'b0);
        cyc(1'b0, 1'b0, 1'b1, 8'h00, 1'b0);
        check_regs("R10 other PID");
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [7:0] p;
        void'($urandom(32'h5EC0_0F11));
        repeat (3) @(posedge clk);
        #1;
        check("R2 reset frame_lo", {24'b0, frame_lo}, 32'h0);
        check("R2 reset frame_hi", {24'b0, frame_hi}, 32'h0);
        check("R2 reset sof_irq", {31'b0, sof_irq}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2, 1'b0);

        // directed corners
        send_sof(11'h7FF, 16, 1'b0);
        idle(3, 1'b0);                  // R9 sticky
        idle(1, 1'b1);                  // R9 clear
        send_sof(11'h000, 16, 1'b1);    // R9 clear racing PID
        send_sof(11'h2A5, 3, 1'b0);     // R6 frame bit flipped
        send_sof(11'h155, 13, 1'b0);    // R5 CRC bit flipped
        send_short(0, 1'b0);
        send_sof(11'h3C1, 16, 1'b0);
        send_short(1, 1'b0);
        send_short(1, 1'b1);
        send_other(8'hE1);
        cyc(1'b1, 1'b0, 1'b0, 8'hA5, 1'b0);   // stray byte outside packet
        check_regs("R10 stray byte");

        // random traffic
        for (int n = 0; n < 400; n++) begin
            case ($urandom_range(0, 5))
                0, 1: send_sof(11'($urandom), 16, $urandom_range(0, 1) == 1);
                2:    send_sof(11'($urandom), int'($urandom_range(0, 15)), 1'b0);
                3:    send_short(int'($urandom_range(0, 1)), $urandom_range(0, 1) == 1);
                default: begin
                    p = 8'($urandom);
                    if (p == 8'hA5) p = 8'h69;
                    send_other(p);
                end
            endcase
            idle(int'($urandom_range(0, 3)), $urandom_range(0, 3) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule